// File: doc/BRIEF.md
# Dual-Lane Serial Flash Command Front End

This block is the slave-side command front end of a serial memory that runs a two-wire SPI mode. Every bit of a transfer moves two at a time on lanes DQ1 and DQ0: the opcode, the parameters and the response data. The block samples the serial clock, chip select and the lanes with the local system clock. It rebuilds the opcode byte and sorts it into one of three classes: read-type, modify-type or unknown.

A read-type opcode starts a response phase. The block raises a start strobe, then pulls response bytes from a downstream controller one at a time and drives them back out on both lanes. The host may end a response at any lane pair. A modify-type opcode is not committed while bytes are still arriving. The block stores up to four parameter bytes. When chip select rises, it issues a one-cycle command strobe, but only if the transfer ended on a whole byte. A command that stops part-way through a byte is dropped. An unknown opcode is ignored until chip select rises.

Top module: `dspi_cmd_front`

## Requirements
- R1: Each rising edge of `sck_i` while `csn_i` is low samples two bits, the higher one on `dq_i[1]`. Bytes travel most significant pair first, so four rising edges make one byte.
- R2: The read-type opcodes are 0x05, 0x70, 0xB5, 0x85, 0x65, 0xE8 and 0xAF. When one of them completes, `rd_start_o` pulses once and `rd_opcode_o` holds that opcode.
- R3: After a read-type opcode, each falling edge of `sck_i` drives the next bit pair onto `dq_o` (`dq_o[1]` the higher bit), starting with bits 7:6 of a byte. A fresh byte is taken from `rd_data_i` on every fourth falling edge, starting with the first, and `rd_load_o` pulses in that cycle.
- R4: Both bits of `dq_oe_o` are high only from the first falling edge of a read response until chip select rises. They are low at all other times.
- R5: Chip select may rise after any pair of a read response. This gives no command strobe and does not affect the decoding of the next transfer.
- R6: The modify-type opcodes are 0x06, 0x04, 0x01, 0x50, 0xB1, 0x81, 0x61, 0xE5, 0x02, 0x42, 0x20, 0xD8, 0xC7, 0x75 and 0x7A. If chip select rises after a whole number of bytes, `cmd_valid_o` pulses for exactly one cycle and `cmd_opcode_o` holds the opcode.
- R7: If chip select rises in the middle of a byte after a modify-type opcode, no `cmd_valid_o` pulse is issued.
- R8: The first four whole bytes after a modify-type opcode appear with the strobe, byte k on `cmd_param_o[8k+7:8k]`. Unused bytes read zero. Later bytes are dropped and `cmd_nparam_o` stops at 4.
- R9: An unknown opcode gives no strobe of any kind and no output enable, whatever follows it before chip select rises.
- R10: A transfer that ends before a full opcode byte produces nothing. The next transfer starts with a fresh opcode.
- R11: After reset, `dq_oe_o`, `dq_o`, `rd_start_o`, `rd_load_o` and `cmd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host, idle low |
| csn_i | input | 1 | Chip select, active low |
| dq_i | input | 2 | Lane input values |
| dq_o | output | 2 | Lane output values during a read response |
| dq_oe_o | output | 2 | Lane output enables |
| rd_start_o | output | 1 | Pulse: a read-type opcode was decoded |
| rd_opcode_o | output | 8 | Opcode that goes with `rd_start_o` |
| rd_load_o | output | 1 | Pulse: `rd_data_i` is taken in this cycle |
| rd_data_i | input | 8 | Next response byte from the controller |
| cmd_valid_o | output | 1 | Pulse: a byte-aligned modify command was committed |
| cmd_opcode_o | output | 8 | Opcode that goes with `cmd_valid_o` |
| cmd_param_o | output | 32 | Captured parameter bytes, byte k at bits 8k+7:8k |
| cmd_nparam_o | output | 3 | Number of captured parameter bytes, 0 to 4 |

## Verification
Most faults show up as a wrong `dq_o` pair, sampled half a serial clock after a falling edge. This covers a pair counter that slips, for example, or a wrong choice of the lane that carries the higher bit. Such a fault is seen inside the first response byte. A wrong transfer class or alignment flag shows up only when chip select rises: a strobe is missing, one appears that should not, or the strobe carries the wrong parameters. A fault in how working state is cleared becomes visible at the first transfer that follows a truncated or unknown one.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int OPC_W = 8;

  typedef enum logic [1:0] {CLS_NONE, CLS_READ, CLS_MODIFY} cmd_class_e;
  typedef enum logic [1:0] {PH_OPC, PH_READ, PH_PARAM, PH_SKIP} phase_e;

  function automatic cmd_class_e classify(input logic [OPC_W-1:0] op);
    case (op)
      8'h05, 8'h70, 8'hB5, 8'h85, 8'h65, 8'hE8, 8'hAF: classify = CLS_READ;
      8'h06, 8'h04, 8'h01, 8'h50, 8'hB1, 8'h81, 8'h61, 8'hE5,
      8'h02, 8'h42, 8'h20, 8'hD8, 8'hC7, 8'h75, 8'h7A: classify = CLS_MODIFY;
      default: classify = CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      st_q   <= {st_q[STAGES-2:0], d_i};
      prev_q <= st_q[STAGES-1];
    end
  end

  assign q_o    = st_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/dspi_rx_deser.sv
module dspi_rx_deser #(
  parameter int LANES = 2,
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic [LANES-1:0] lanes_i,
  output logic [W-1:0]     byte_o,
  output logic             done_o,
  output logic             aligned_o
);
  localparam int PAIRS = W / LANES;
  localparam int CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (shift_i) begin
      sr_q   <= {sr_q[W-LANES-1:0], lanes_i};
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign byte_o    = sr_q;
  assign done_o    = done_q;
  assign aligned_o = (cnt_q == '0);
endmodule

// File: rtl/dspi_tx_ser.sv
module dspi_tx_ser #(
  parameter int LANES = 2,
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [W-1:0]     data_i,
  output logic             load_o,
  output logic [LANES-1:0] lanes_o,
  output logic [LANES-1:0] oe_o
);
  localparam int PAIRS = W / LANES;
  localparam int CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);

  logic [W-1:0]     sr_q;
  logic [CW-1:0]    cnt_q;
  logic [LANES-1:0] lanes_q;
  logic             oe_q;

  assign load_o = step_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      lanes_q <= '0;
      oe_q    <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      lanes_q <= '0;
      oe_q    <= 1'b0;
    end else if (step_i) begin
      oe_q  <= 1'b1;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (load_o) begin
        lanes_q <= data_i[W-1 -: LANES];
        sr_q    <= data_i << LANES;
      end else begin
        lanes_q <= sr_q[W-1 -: LANES];
        sr_q    <= sr_q << LANES;
      end
    end
  end

  assign lanes_o = lanes_q;
  assign oe_o    = {LANES{oe_q}};
endmodule

// File: rtl/dspi_cmd_front.sv
module dspi_cmd_front
  import dspi_pkg::*;
#(
  parameter int LANES = 2,
  parameter int MAX_PARAM = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NP_W = $clog2(MAX_PARAM + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sck_i,
  input  logic                       csn_i,
  input  logic [LANES-1:0]           dq_i,
  output logic [LANES-1:0]           dq_o,
  output logic [LANES-1:0]           dq_oe_o,
  output logic                       rd_start_o,
  output logic [OPC_W-1:0]           rd_opcode_o,
  output logic                       rd_load_o,
  input  logic [OPC_W-1:0]           rd_data_i,
  output logic                       cmd_valid_o,
  output logic [OPC_W-1:0]           cmd_opcode_o,
  output logic [MAX_PARAM*OPC_W-1:0] cmd_param_o,
  output logic [NP_W-1:0]            cmd_nparam_o
);
  localparam int SW = LANES + 2;
  localparam int CS_B = LANES + 1;
  localparam int SCK_B = LANES;

  logic [SW-1:0] pin_q, pin_rise, pin_fall;
  logic csn_s, cs_rise, sck_r, sck_f;

  dspi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SW'(1) << CS_B)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({csn_i, sck_i, dq_i}),
    .q_o(pin_q), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign csn_s   = pin_q[CS_B];
  assign cs_rise = pin_rise[CS_B];
  assign sck_r   = pin_rise[SCK_B] & ~csn_s;
  assign sck_f   = pin_fall[SCK_B] & ~csn_s;

  logic [OPC_W-1:0] rx_byte;
  logic rx_done, rx_aligned;

  dspi_rx_deser #(.LANES(LANES), .W(OPC_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(csn_s), .shift_i(sck_r),
    .lanes_i(pin_q[LANES-1:0]), .byte_o(rx_byte), .done_o(rx_done),
    .aligned_o(rx_aligned)
  );

  phase_e phase_q;
  logic tx_step;
  assign tx_step = sck_f && (phase_q == PH_READ);

  dspi_tx_ser #(.LANES(LANES), .W(OPC_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(csn_s), .step_i(tx_step),
    .data_i(rd_data_i), .load_o(rd_load_o), .lanes_o(dq_o), .oe_o(dq_oe_o)
  );

  logic [MAX_PARAM-1:0][OPC_W-1:0] par_q;
  logic [NP_W-1:0]  np_q;
  logic [OPC_W-1:0] op_q;
  logic             rd_start_q, cmd_valid_q;
  logic [OPC_W-1:0] rd_op_q, cmd_op_q;
  logic [MAX_PARAM-1:0][OPC_W-1:0] cmd_par_q;
  logic [NP_W-1:0]  cmd_np_q;
  cmd_class_e       cls;

  assign cls = classify(rx_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OPC;
      par_q   <= '0;
      np_q    <= '0;
      op_q    <= '0;
    end else if (csn_s) begin
      phase_q <= PH_OPC;
      par_q   <= '0;
      np_q    <= '0;
    end else if (rx_done) begin
      unique case (phase_q)
        PH_OPC: begin
          op_q <= rx_byte;
          unique case (cls)
            CLS_READ:   phase_q <= PH_READ;
            CLS_MODIFY: phase_q <= PH_PARAM;
            default:    phase_q <= PH_SKIP;
          endcase
        end
        PH_PARAM: begin
          if (np_q < NP_W'(MAX_PARAM)) begin
            par_q[np_q] <= rx_byte;
            np_q        <= np_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Output registers hold their value between strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_start_q  <= 1'b0;
      rd_op_q     <= '0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= '0;
      cmd_par_q   <= '0;
      cmd_np_q    <= '0;
    end else begin
      rd_start_q  <= 1'b0;
      cmd_valid_q <= 1'b0;
      if (!csn_s && rx_done && phase_q == PH_OPC && cls == CLS_READ) begin
        rd_start_q <= 1'b1;
        rd_op_q    <= rx_byte;
      end
      if (cs_rise && phase_q == PH_PARAM && rx_aligned) begin
        cmd_valid_q <= 1'b1;
        cmd_op_q    <= op_q;
        cmd_par_q   <= par_q;
        cmd_np_q    <= np_q;
      end
    end
  end

  assign rd_start_o   = rd_start_q;
  assign rd_opcode_o  = rd_op_q;
  assign cmd_valid_o  = cmd_valid_q;
  assign cmd_opcode_o = cmd_op_q;
  assign cmd_param_o  = cmd_par_q;
  assign cmd_nparam_o = cmd_np_q;
endmodule

// File: rtl/dspi_cmd_front_chk.sv
module dspi_cmd_front_chk #(
  parameter int LANES = 2,
  parameter int MAX_PARAM = 4,
  parameter int NP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_s,
  input logic             cs_rise,
  input logic             rd_start_o,
  input logic             rd_load_o,
  input logic             cmd_valid_o,
  input logic [LANES-1:0] dq_oe_o,
  input logic [NP_W-1:0]  cmd_nparam_o
);
  AST_OE_OFF_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> dq_oe_o == '0); // R4
  AST_LOAD_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_o |=> dq_oe_o == {LANES{1'b1}}); // R3
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R6
  AST_CMD_AFTER_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(cs_rise)); // R7
  AST_NPARAM_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_nparam_o <= NP_W'(MAX_PARAM)); // R8
  AST_RD_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_o |=> !rd_start_o && !cmd_valid_o); // R2
endmodule

bind dspi_cmd_front dspi_cmd_front_chk #(.LANES(LANES), .MAX_PARAM(MAX_PARAM), .NP_W(NP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_s(csn_s), .cs_rise(cs_rise),
  .rd_start_o(rd_start_o), .rd_load_o(rd_load_o), .cmd_valid_o(cmd_valid_o),
  .dq_oe_o(dq_oe_o), .cmd_nparam_o(cmd_nparam_o)
);

// File: tb/dspi_cmd_front_tb.sv
`timescale 1ns/1ps
module dspi_cmd_front_tb;
  logic clk = 0, rst_ni = 0, sck = 0, csn = 1;
  logic [1:0] dq_in = '0;
  logic [1:0] dq_out, dq_oe;
  logic rd_start, rd_load, cmd_valid;
  logic [7:0] rd_op, rd_data, cmd_op;
  logic [31:0] cmd_par;
  logic [2:0] cmd_np;

  int tests = 0, fails = 0;
  int cyc = 0, last_chg = 0, oe_bad = 0;
  logic exp_oe = 0;
  int rd_idx = 0, n_start = 0, n_valid = 0;
  logic [7:0] m_rd_op, m_op;
  logic [31:0] m_par;
  logic [2:0] m_np;

  always #2.5 clk = ~clk;

  dspi_cmd_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .rd_start_o(rd_start), .rd_opcode_o(rd_op),
    .rd_load_o(rd_load), .rd_data_i(rd_data), .cmd_valid_o(cmd_valid),
    .cmd_opcode_o(cmd_op), .cmd_param_o(cmd_par), .cmd_nparam_o(cmd_np)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'(8'hC3 ^ (k * 29));
  endfunction
  assign rd_data = pat(rd_idx);

  // Monitor and per-clock output-enable model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (csn) rd_idx <= 0; else if (rd_load) rd_idx <= rd_idx + 1;
    if (rd_start) begin n_start <= n_start + 1; m_rd_op <= rd_op; end
    if (cmd_valid) begin
      n_valid <= n_valid + 1; m_op <= cmd_op; m_par <= cmd_par; m_np <= cmd_np;
    end
  end
  always @(negedge clk)
    if (rst_ni && cyc - last_chg > 6 && dq_oe != {2{exp_oe}}) oe_bad <= oe_bad + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_begin();
    csn = 0; half();
  endtask

  task automatic cs_end();
    half(); csn = 1; exp_oe = 0; last_chg = cyc;
    repeat (12) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int npairs = 4);
    for (int p = 0; p < npairs; p++) begin
      dq_in = b[7-2*p -: 2];
      half(); sck = 1; half(); sck = 0;
    end
  endtask

  // Reads n pairs after a read opcode, checking every pair (R3)
  task automatic read_pairs(input int n);
    logic [7:0] b;
    exp_oe = 1; last_chg = cyc;
    for (int j = 0; j < n; j++) begin
      half();
      b = pat(j / 4);
      tests++;
      if (dq_out !== b[7-2*(j%4) -: 2] || dq_oe !== 2'b11) begin
        fails++;
        $display("FAIL R3 pair %0d actual=%0h/%0h expected=%0h/3", j, dq_out, dq_oe, b[7-2*(j%4) -: 2]);
      end
      sck = 1; half(); sck = 0;
    end
  endtask

  task automatic mod_cmd(input logic [7:0] op, input logic [7:0] p [], input int tail,
                         input bit exp_strobe, input string req);
    int v0 = n_valid;
    logic [31:0] ep = '0;
    cs_begin();
    send(op);
    foreach (p[i]) begin
      send(p[i]);
      if (i < 4) ep[8*i +: 8] = p[i];
    end
    if (tail > 0) send(8'hFF, tail);
    cs_end();
    check({req, " strobe count"}, n_valid - v0, exp_strobe ? 1 : 0);
    if (exp_strobe) begin
      check({req, " opcode"}, m_op, op);
      check({req, " params"}, m_par, ep);
      check({req, " nparam"}, m_np, (p.size() > 4) ? 4 : p.size());
    end
  endtask

  initial begin
    logic [7:0] none [];
    logic [7:0] one [];
    logic [7:0] six [];
    logic [7:0] three [];
    int s0, v0;
    none = new[0];
    one = '{8'h5A};
    six = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    three = '{8'h01, 8'hE0, 8'h7F};
    repeat (4) @(negedge clk);
    check("R11 reset oe", dq_oe, 0);
    check("R11 reset strobes", {rd_start, rd_load, cmd_valid, dq_out}, 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);

    mod_cmd(8'h06, none, 0, 1, "R6 R1 write-enable");
    mod_cmd(8'h61, one, 0, 1, "R8 one-byte write");
    mod_cmd(8'h02, six, 0, 1, "R8 program overflow");
    mod_cmd(8'h06, none, 1, 0, "R7 misaligned by one pair");
    mod_cmd(8'hD8, three, 3, 0, "R7 misaligned by three pairs");

    // R10: partial opcode, then a clean command
    v0 = n_valid; s0 = n_start;
    cs_begin(); send(8'h05, 3); cs_end();
    check("R10 partial opcode", {n_valid - v0, n_start - s0}, 0);
    mod_cmd(8'h04, none, 0, 1, "R10 fresh after partial");

    // R2 R3 R5: status read ended mid-byte
    v0 = n_valid; s0 = n_start;
    cs_begin(); send(8'h05);
    check("R2 read start", n_start - s0, 1);
    check("R2 read opcode", m_rd_op, 8'h05);
    read_pairs(14);
    check("R3 byte loads", rd_idx, 4);
    cs_end();
    check("R5 no strobe after read", n_valid - v0, 0);
    check("R4 oe cleared", dq_oe, 0);

    // R5: short read of one pair, then a command decodes normally
    cs_begin(); send(8'h70); read_pairs(1); cs_end();
    check("R2 second read opcode", m_rd_op, 8'h70);
    mod_cmd(8'h20, three, 0, 1, "R5 command after short read");

    // R9: unknown opcode followed by bytes
    v0 = n_valid; s0 = n_start;
    cs_begin(); send(8'hFF); send(8'h06); send(8'h05); send(8'h12);
    check("R9 oe stays off", dq_oe, 0);
    cs_end();
    check("R9 no strobes", {n_valid - v0, n_start - s0}, 0);
    mod_cmd(8'hC7, none, 0, 1, "R9 fresh after unknown");

    check("R4 per-clock oe mismatches", oe_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule